// File: doc/BRIEF.md
# Linked List Rule Match Pipeline

This block is the second half of a two-level packet classifier. A range-tree stage picks an interval for one header field and hands over the head pointer of a rule list together with the header fields it did not examine: source port, destination port and protocol. The pipeline then walks that list, visiting one node per stage. Stage k holds the k-th node of every list, so a list can be no longer than the number of stages. Each node carries one rule's remaining fields, a priority, an action and a link to the next node, which sits in the following stage.

At every stage all stored fields are compared with the header at once. A rule that matches and has better precedence than the best result so far replaces that result. After the last stage, the best action and priority leave the block. The block accepts one packet per cycle and keeps packets in order. A simple write port loads any node of any stage.

Top module: `ll_rule_match_pipe`

## Requirements
- R1: A packet presented with `in_valid` high produces `out_valid` high exactly STAGES clock edges later, carrying that packet's result. One packet is accepted every cycle, and results leave in arrival order.
- R2: With `wr_en` high, the node at address `wr_addr` in stage `wr_stage` is overwritten at the clock edge with all `wr_*` fields. A packet entering afterwards sees the new contents.
- R3: A node matches only when the source port, destination port and protocol tests all pass. Each port test is chosen by its 2-bit mode: 0 = wildcard (always passes), 1 = point (field equals the low bound; the high bound is ignored), 2 or 3 = range (low <= field <= high, inclusive at both ends).
- R4: The running result is replaced only by a matching node whose priority value is strictly smaller (smaller means higher precedence). On a tie, the earlier node in the list is kept.
- R5: If no node matches, `out_hit` is 0 and `out_prio` and `out_action` are both 0.
- R6: A node with `next_valid` = 0 ends the list: later stages pass the result through and ignore their memory. A packet with `in_head_valid` = 0 visits no node and gives no hit.
- R7: A port in range mode with low bound all zeros and high bound all ones matches every value of that field, including 0 and all ones.
- R8: The protocol test passes when the node's `proto_any` flag is 1, or when the stored protocol equals the header protocol exactly.
- R9: While `rst_n` is low, and until the first accepted packet has travelled through, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| in_valid | input | 1 | A packet is presented this cycle |
| in_head_valid | input | 1 | The list head pointer is meaningful |
| in_head | input | AW | Address of the first node in stage 0 |
| in_sport | input | PORT_W | Header source port |
| in_dport | input | PORT_W | Header destination port |
| in_proto | input | PROTO_W | Header protocol |
| wr_en | input | 1 | Write one node |
| wr_stage | input | SW | Stage that holds the node |
| wr_addr | input | AW | Node address inside that stage |
| wr_sp_mode | input | 2 | Source port test mode |
| wr_sp_lo | input | PORT_W | Source port low bound, or the point value |
| wr_sp_hi | input | PORT_W | Source port high bound |
| wr_dp_mode | input | 2 | Destination port test mode |
| wr_dp_lo | input | PORT_W | Destination port low bound, or the point value |
| wr_dp_hi | input | PORT_W | Destination port high bound |
| wr_proto_any | input | 1 | Protocol is a wildcard |
| wr_proto | input | PROTO_W | Exact protocol value |
| wr_prio | input | PRIO_W | Rule priority (smaller wins) |
| wr_action | input | ACT_W | Rule action |
| wr_next_valid | input | 1 | A next node exists |
| wr_next | input | AW | Address of the next node in the following stage |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Some rule matched |
| out_prio | output | PRIO_W | Priority of the winning rule |
| out_action | output | ACT_W | Action of the winning rule |

## Verification
Every search result is due exactly STAGES clock edges after the cycle in which its packet was driven, and a node write takes effect at the very next edge. The bench drives inputs on the falling edge. On each falling edge it compares the outputs with the entry that a behavioural list-walking model pushed STAGES falling edges earlier, so idle cycles are checked as well as packet cycles. Node writes are made only while no packet is in flight, so the model's view of memory matches what each packet reads at every stage.

// File: rtl/ll_rule_match_pipe.sv
`timescale 1ns/1ps
module ll_rule_match_pipe #(
  parameter int STAGES  = 4,
  parameter int DEPTH   = 16,
  parameter int PORT_W  = 16,
  parameter int PROTO_W = 8,
  parameter int PRIO_W  = 8,
  parameter int ACT_W   = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_head_valid,
  input  logic [AW-1:0]      in_head,
  input  logic [PORT_W-1:0]  in_sport,
  input  logic [PORT_W-1:0]  in_dport,
  input  logic [PROTO_W-1:0] in_proto,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_stage,
  input  logic [AW-1:0]      wr_addr,
  input  logic [1:0]         wr_sp_mode,
  input  logic [PORT_W-1:0]  wr_sp_lo,
  input  logic [PORT_W-1:0]  wr_sp_hi,
  input  logic [1:0]         wr_dp_mode,
  input  logic [PORT_W-1:0]  wr_dp_lo,
  input  logic [PORT_W-1:0]  wr_dp_hi,
  input  logic               wr_proto_any,
  input  logic [PROTO_W-1:0] wr_proto,
  input  logic [PRIO_W-1:0]  wr_prio,
  input  logic [ACT_W-1:0]   wr_action,
  input  logic               wr_next_valid,
  input  logic [AW-1:0]      wr_next,
  output logic               out_valid,
  output logic               out_hit,
  output logic [PRIO_W-1:0]  out_prio,
  output logic [ACT_W-1:0]   out_action
);

  typedef struct packed {
    logic [1:0]         sm;
    logic [PORT_W-1:0]  slo;
    logic [PORT_W-1:0]  shi;
    logic [1:0]         dm;
    logic [PORT_W-1:0]  dlo;
    logic [PORT_W-1:0]  dhi;
    logic               pany;
    logic [PROTO_W-1:0] proto;
    logic [PRIO_W-1:0]  prio;
    logic [ACT_W-1:0]   act;
    logic               nv;
    logic [AW-1:0]      nxt;
  } node_t;

  function automatic logic port_ok(input logic [1:0] m, input logic [PORT_W-1:0] v,
                                   input logic [PORT_W-1:0] lo, input logic [PORT_W-1:0] hi);
    case (m)
      2'd0:    return 1'b1;
      2'd1:    return v == lo;
      default: return (lo <= v) && (v <= hi);
    endcase
  endfunction

  node_t wr_node;
  assign wr_node = '{sm: wr_sp_mode, slo: wr_sp_lo, shi: wr_sp_hi,
                     dm: wr_dp_mode, dlo: wr_dp_lo, dhi: wr_dp_hi,
                     pany: wr_proto_any, proto: wr_proto, prio: wr_prio,
                     act: wr_action, nv: wr_next_valid, nxt: wr_next};

  logic               pv    [1:STAGES];
  logic               pact  [1:STAGES];
  logic [AW-1:0]      pptr  [1:STAGES];
  logic [PORT_W-1:0]  psp   [1:STAGES];
  logic [PORT_W-1:0]  pdp   [1:STAGES];
  logic [PROTO_W-1:0] ppr   [1:STAGES];
  logic               pfnd  [1:STAGES];
  logic [PRIO_W-1:0]  pprio [1:STAGES];
  logic [ACT_W-1:0]   pact_o[1:STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    node_t mem [DEPTH];
    node_t rd;
    logic               c_v, c_act, c_fnd;
    logic [AW-1:0]      c_ptr;
    logic [PORT_W-1:0]  c_sp, c_dp;
    logic [PROTO_W-1:0] c_pr;
    logic [PRIO_W-1:0]  c_prio;
    logic [ACT_W-1:0]   c_aout;
    logic               hit, take;

    if (s == 0) begin : g_head
      assign c_v    = in_valid;
      assign c_act  = in_head_valid;
      assign c_ptr  = in_head;
      assign c_sp   = in_sport;
      assign c_dp   = in_dport;
      assign c_pr   = in_proto;
      assign c_fnd  = 1'b0;
      assign c_prio = '0;
      assign c_aout = '0;
    end else begin : g_mid
      assign c_v    = pv[s];
      assign c_act  = pact[s];
      assign c_ptr  = pptr[s];
      assign c_sp   = psp[s];
      assign c_dp   = pdp[s];
      assign c_pr   = ppr[s];
      assign c_fnd  = pfnd[s];
      assign c_prio = pprio[s];
      assign c_aout = pact_o[s];
    end

    always_ff @(posedge clk)
      if (wr_en && wr_stage == SW'(s)) mem[wr_addr] <= wr_node;

    assign rd   = mem[c_ptr];
    assign hit  = c_act
               && port_ok(rd.sm, c_sp, rd.slo, rd.shi)
               && port_ok(rd.dm, c_dp, rd.dlo, rd.dhi)
               && (rd.pany || rd.proto == c_pr);
    assign take = hit && (!c_fnd || rd.prio < c_prio);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pv[s+1]     <= 1'b0;
        pact[s+1]   <= 1'b0;
        pptr[s+1]   <= '0;
        psp[s+1]    <= '0;
        pdp[s+1]    <= '0;
        ppr[s+1]    <= '0;
        pfnd[s+1]   <= 1'b0;
        pprio[s+1]  <= '0;
        pact_o[s+1] <= '0;
      end else begin
        pv[s+1]     <= c_v;
        pact[s+1]   <= c_v && c_act && rd.nv;
        pptr[s+1]   <= rd.nxt;
        psp[s+1]    <= c_sp;
        pdp[s+1]    <= c_dp;
        ppr[s+1]    <= c_pr;
        pfnd[s+1]   <= c_v && (c_fnd || take);
        pprio[s+1]  <= !c_v ? '0 : take ? rd.prio : c_prio;
        pact_o[s+1] <= !c_v ? '0 : take ? rd.act  : c_aout;
      end

    if (s > 0) begin : g_chk
      a_r4_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
        pv[s+1] && $past(pv[s]) && $past(pfnd[s]) |-> pfnd[s+1] && pprio[s+1] <= $past(pprio[s]));
      a_r6_list_ended: assert property (@(posedge clk) disable iff (!rst_n)
        pv[s+1] && !$past(pact[s]) |-> !pact[s+1]);
    end
  end

  assign out_valid  = pv[STAGES];
  assign out_hit    = pfnd[STAGES];
  assign out_prio   = pprio[STAGES];
  assign out_action = pact_o[STAGES];

  a_r1_hit_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_hit);
  a_r5_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_prio == '0 && out_action == '0);
  a_r2_stage_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> {1'b0, wr_stage} < (SW+1)'(STAGES));
  a_r6_no_head_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_head_valid |=> !pfnd[1]);

endmodule

// File: tb/tb_ll_rule_match_pipe.sv
`timescale 1ns/1ps
module tb_ll_rule_match_pipe;
  localparam int STAGES = 4, DEPTH = 16, PW = 16, PRW = 8, PRIW = 8, AW_ = 8;
  localparam int AW = 4, SW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_head_valid = 0;
  logic [AW-1:0] in_head = 0;
  logic [PW-1:0] in_sport = 0, in_dport = 0;
  logic [PRW-1:0] in_proto = 0;
  logic wr_en = 0;
  logic [SW-1:0] wr_stage = 0;
  logic [AW-1:0] wr_addr = 0, wr_next = 0;
  logic [1:0] wr_sp_mode = 0, wr_dp_mode = 0;
  logic [PW-1:0] wr_sp_lo = 0, wr_sp_hi = 0, wr_dp_lo = 0, wr_dp_hi = 0;
  logic wr_proto_any = 0, wr_next_valid = 0;
  logic [PRW-1:0] wr_proto = 0;
  logic [PRIW-1:0] wr_prio = 0;
  logic [AW_-1:0] wr_action = 0;
  logic out_valid, out_hit;
  logic [PRIW-1:0] out_prio;
  logic [AW_-1:0] out_action;

  ll_rule_match_pipe dut (.*);

  always #2.5 clk = ~clk;

  typedef struct { bit v; bit hit; int prio; int act; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  string cur_tag = "R1";

  int m_sm[STAGES][DEPTH], m_slo[STAGES][DEPTH], m_shi[STAGES][DEPTH];
  int m_dm[STAGES][DEPTH], m_dlo[STAGES][DEPTH], m_dhi[STAGES][DEPTH];
  int m_pany[STAGES][DEPTH], m_pr[STAGES][DEPTH], m_prio[STAGES][DEPTH];
  int m_act[STAGES][DEPTH], m_nv[STAGES][DEPTH], m_nx[STAGES][DEPTH];

  function automatic bit pok(int m, int v, int lo, int hi);
    if (m == 0) return 1;
    if (m == 1) return v == lo;
    return lo <= v && v <= hi;
  endfunction

  function automatic exp_t model(bit hv, int h, int sp, int dp, int pr);
    exp_t e;
    int ptr = h;
    bit act = hv;
    e.v = 1; e.hit = 0; e.prio = 0; e.act = 0; e.tag = cur_tag;
    for (int s = 0; s < STAGES; s++) begin
      if (!act) break;
      if (pok(m_sm[s][ptr], sp, m_slo[s][ptr], m_shi[s][ptr]) &&
          pok(m_dm[s][ptr], dp, m_dlo[s][ptr], m_dhi[s][ptr]) &&
          (m_pany[s][ptr] != 0 || m_pr[s][ptr] == pr) &&
          (!e.hit || m_prio[s][ptr] < e.prio)) begin
        e.hit = 1; e.prio = m_prio[s][ptr]; e.act = m_act[s][ptr];
      end
      act = m_nv[s][ptr] != 0;
      ptr = m_nx[s][ptr];
    end
    return e;
  endfunction

  task automatic op();
    exp_t e, n;
    e = q.pop_front();
    checks++;
    if (out_valid !== e.v)
      begin errors++; $display("FAIL %s out_valid=%0b expected %0b", e.tag, out_valid, e.v); end
    else if (e.v && (out_hit !== e.hit || out_prio !== PRIW'(e.prio) || out_action !== AW_'(e.act))) begin
      errors++;
      $display("FAIL %s hit/prio/act=%0b/%0d/%0h expected %0b/%0d/%0h",
               e.tag, out_hit, out_prio, out_action, e.hit, e.prio, e.act);
    end
    if (in_valid) n = model(in_head_valid, in_head, in_sport, in_dport, in_proto);
    else begin n.v = 0; n.hit = 0; n.prio = 0; n.act = 0; n.tag = cur_tag; end
    q.push_back(n);
    if (wr_en) begin
      m_sm[wr_stage][wr_addr] = wr_sp_mode;  m_slo[wr_stage][wr_addr] = wr_sp_lo;
      m_shi[wr_stage][wr_addr] = wr_sp_hi;   m_dm[wr_stage][wr_addr] = wr_dp_mode;
      m_dlo[wr_stage][wr_addr] = wr_dp_lo;   m_dhi[wr_stage][wr_addr] = wr_dp_hi;
      m_pany[wr_stage][wr_addr] = wr_proto_any; m_pr[wr_stage][wr_addr] = wr_proto;
      m_prio[wr_stage][wr_addr] = wr_prio;   m_act[wr_stage][wr_addr] = wr_action;
      m_nv[wr_stage][wr_addr] = wr_next_valid; m_nx[wr_stage][wr_addr] = wr_next;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op();
  endtask

  task automatic wn(int s, int a, int sm, int slo, int shi, int dm, int dlo, int dhi,
                    int pany, int pr, int prio, int act, int nv, int nx);
    wr_en = 1; wr_stage = SW'(s); wr_addr = AW'(a);
    wr_sp_mode = 2'(sm); wr_sp_lo = PW'(slo); wr_sp_hi = PW'(shi);
    wr_dp_mode = 2'(dm); wr_dp_lo = PW'(dlo); wr_dp_hi = PW'(dhi);
    wr_proto_any = 1'(pany); wr_proto = PRW'(pr); wr_prio = PRIW'(prio);
    wr_action = AW_'(act); wr_next_valid = 1'(nv); wr_next = AW'(nx);
    cur_tag = "R2";
    op();
    wr_en = 0;
  endtask

  task automatic pk(int hv, int h, int sp, int dp, int pr, string tag);
    in_valid = 1; in_head_valid = 1'(hv); in_head = AW'(h);
    in_sport = PW'(sp); in_dport = PW'(dp); in_proto = PRW'(pr);
    cur_tag = tag;
    op();
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < STAGES; s++)
      for (int a = 0; a < DEPTH; a++) begin
        m_sm[s][a] = 0; m_slo[s][a] = 0; m_shi[s][a] = 0; m_dm[s][a] = 0;
        m_dlo[s][a] = 0; m_dhi[s][a] = 0; m_pany[s][a] = 0; m_pr[s][a] = 0;
        m_prio[s][a] = 0; m_act[s][a] = 0; m_nv[s][a] = 0; m_nx[s][a] = 0;
      end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R9 out_valid=%0b expected 0 in reset", out_valid); end
    rst_n = 1;
    for (int i = 0; i < STAGES; i++) begin
      exp_t e; e.v = 0; e.hit = 0; e.prio = 0; e.act = 0; e.tag = "R9"; q.push_back(e);
    end
    // list A: head stage0 addr1 -> s1 a2 -> s2 a3 -> s3 a7
    wn(0, 1, 2, 100, 200, 0, 0, 0, 0, 6, 10, 'hA1, 1, 2);
    wn(1, 2, 0, 0, 0, 1, 80, 0, 1, 0, 5, 'hB2, 1, 3);
    wn(2, 3, 2, 0, 'hFFFF, 2, 50, 2000, 0, 17, 5, 'hC3, 1, 7);
    wn(3, 7, 1, 150, 0, 0, 0, 0, 1, 0, 20, 'hD4, 0, 0);
    // list B: single node, a tempting unreachable node behind it
    wn(0, 4, 0, 0, 0, 0, 0, 0, 1, 0, 1, 'hE5, 0, 0);
    wn(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 'hFF, 1, 0);
    idle(STAGES);
    pk(1, 1, 150, 80, 6, "R4");       // A1 then better B2
    pk(1, 1, 150, 80, 17, "R4");      // B2 and C3 tie: keep B2
    pk(1, 1, 150, 1500, 17, "R3");    // only C3 and point D4(20): C3
    pk(1, 1, 150, 5, 9, "R3");        // point sp hit only: D4
    pk(1, 1, 151, 5, 9, "R5");        // nothing
    pk(1, 1, 200, 5, 6, "R3");        // inclusive upper bound
    pk(1, 1, 100, 5, 6, "R3");        // inclusive lower bound
    pk(1, 1, 201, 5, 6, "R5");
    pk(1, 1, 0, 1500, 17, "R7");
    pk(1, 1, 'hFFFF, 1500, 17, "R7");
    pk(1, 1, 120, 3000, 6, "R8");     // exact protocol
    pk(1, 1, 120, 3000, 7, "R8");     // protocol mismatch: miss
    pk(1, 1, 150, 3000, 7, "R8");     // wildcard protocol at D4
    pk(1, 4, 9, 9, 9, "R6");          // list ends before prio 0 node
    pk(0, 4, 9, 9, 9, "R6");          // no head
    for (int i = 0; i < 60; i++) begin
      int sps[5] = '{100, 150, 200, 0, 'hFFFF};
      int dps[3] = '{80, 1500, 5};
      int prs[3] = '{6, 17, 9};
      pk(($urandom % 4) != 0, ($urandom % 2) ? 1 : 4,
         ($urandom % 6 == 5) ? int'($urandom % 65536) : sps[$urandom % 5],
         dps[$urandom % 3], prs[$urandom % 3], "R1");
    end
    idle(STAGES);
    wn(0, 1, 2, 100, 200, 0, 0, 0, 0, 6, 1, 'h77, 1, 2);
    pk(1, 1, 150, 80, 6, "R2");       // rewritten head now wins
    idle(STAGES);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule